// File: doc/BRIEF.md
# Multi-Mode Serial Port

This block is a full-duplex serial port that keeps one register address for data. A write to that address loads the transmit shifter. A read returns a separate receive holding register. Three framing modes are available. The first is a synchronous eight-bit shift mode. In that mode the bidirectional data pin carries data in both directions and the transmit pin drives the shift clock. The other two are asynchronous modes with a 10-bit frame and an 11-bit frame. The 11-bit frame carries a ninth data bit that software can write.

In the asynchronous modes, bit timing comes from an external tick input that runs at the oversampling rate. In shift mode, bit timing comes from a divider on the system clock. The receive path is double-buffered: a new frame can shift in while the previous byte still sits unread in the holding register. Two sticky flags, transmit-done and receive-full, can be used as interrupt requests. Software clears each flag with its own clear input.

Top module: `mm_serial_port`

## Requirements
- R1: After reset, `txd` is 1, `rxd_oe` is 0, and `tx_flag`, `rx_flag`, `frame_err`, `rd_data` and `rd_bit9` are all 0.
- R2: With `mode`=01, a write sends start 0, then eight data bits LSB first, then stop 1, each bit lasting OVS ticks. `tx_flag` is set when the frame ends.
- R3: With `mode`=10 or 11, the frame carries `tx_bit9` (captured at the write) between the eighth data bit and the stop bit.
- R4: A write while a transmission or shift operation is in progress is ignored. The frame already on the line completes unchanged and no further frame follows.
- R5: With `mode`=01, a received frame loads `rd_data` with the data byte, loads `rd_bit9` with the sampled stop bit, and sets `rx_flag`.
- R6: With `mode`=10 or 11, a received frame loads `rd_bit9` with the received ninth bit.
- R7: A stop bit sampled as 0 sets `frame_err`. The byte is still placed in `rd_data`. `clr_rx_flag` also clears `frame_err`.
- R8: If `rx_flag` is still set when a new frame completes, the new frame is discarded and `rd_data` keeps the old byte.
- R9: The receiver checks a low start level with a majority vote of oversamples 7, 8 and 9 (OVS=16). A low pulse shorter than half a bit starts no reception.
- R10: With `mode`=00, a write shifts eight bits LSB first out on `rxd_out` with `rxd_oe`=1. Each bit is valid at the rising edge of `txd`. The clock period in system cycles is 6 or 3 when `shift_fast`=0 and 4 or 2 when `shift_fast`=1; `shift_x2`=1 picks the shorter period.
- R11: With `mode`=00, a pulse on `rx_go` clocks eight bits in from `rxd_in`, LSB first, sampled at each rising edge of `txd`. The byte lands in the holding register and sets `rx_flag`.
- R12: `tx_flag` and `rx_flag` stay set until their clear input is pulsed.
- R13: Reception continues while the holding register is full. If `rx_flag` is cleared before the new frame ends, that frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 shift, 01 async 10-bit, 1x async 11-bit |
| shift_fast | input | 1 | Shift-mode divider set: 0 gives 6/3, 1 gives 4/2 |
| shift_x2 | input | 1 | Picks the shorter shift-clock period |
| baud_tick | input | 1 | Oversampling tick for the asynchronous modes |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth transmit bit, captured at the write |
| rx_go | input | 1 | Starts a shift-mode reception |
| clr_tx_flag | input | 1 | Clears `tx_flag` |
| clr_rx_flag | input | 1 | Clears `rx_flag` and `frame_err` |
| rxd_in | input | 1 | Receive pin input |
| rxd_out | output | 1 | Data driven onto the receive pin in shift mode |
| rxd_oe | output | 1 | Output enable of the receive pin |
| txd | output | 1 | Serial output, or shift clock in mode 00 |
| rd_data | output | 8 | Receive holding register |
| rd_bit9 | output | 1 | Received ninth bit or stop bit |
| frame_err | output | 1 | Stop bit of the held frame was 0 |
| tx_flag | output | 1 | Transmission done |
| rx_flag | output | 1 | Holding register full |

## Verification
The bench builds the block with its defaults: OVS=16 and shift divisors 6, 3, 4 and 2. A tick arrives every four clocks, so an asynchronous bit lasts 64 cycles. That length is enough for the bench to place a three-tick glitch well under the half-bit threshold. It also lets the bench clear the flag in the middle of a frame that is arriving behind an unread byte. All four divisors are used, so the period of the odd divisor, where the clock halves are unequal, is measured along with the even ones.

// File: rtl/sp_pkg.sv
package sp_pkg;
    // Mode encoding: 00 synchronous shift, 01 async 10-bit, 1x async 11-bit
    localparam logic [1:0] MODE_SHIFT  = 2'b00;
    localparam int         DATA_BITS   = 8;

    // True when the mode selects the synchronous shift engine
    function automatic logic mode_is_shift(input logic [1:0] m);
        return m == MODE_SHIFT;
    endfunction

    // True when the asynchronous frame carries a ninth data bit
    function automatic logic mode_has_nine(input logic [1:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/sp_shift_engine.sv
// Synchronous eight-bit shifter. The shift clock is low for the first
// half of each bit period and high for the rest. Received data is captured
// in the first high cycle. Transmit data moves on at the end of each period.
// Assumes the rate selects stay stable while busy.
module sp_shift_engine #(
    parameter int DIV_CS = 6,
    parameter int DIV_CF = 3,
    parameter int DIV_FS = 4,
    parameter int DIV_FF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fast,
    input  logic       dbl,
    input  logic       start_tx,
    input  logic       start_rx,
    input  logic [7:0] tx_data,
    input  logic       rx_pin,
    output logic       busy,
    output logic       sclk,
    output logic       dout,
    output logic       doe,
    output logic       done_tx,
    output logic       done_rx,
    output logic [7:0] rx_data
);
    localparam int DMAX_A = (DIV_CS > DIV_CF) ? DIV_CS : DIV_CF;
    localparam int DMAX_B = (DIV_FS > DIV_FF) ? DIV_FS : DIV_FF;
    localparam int DMAX   = (DMAX_A > DMAX_B) ? DMAX_A : DMAX_B;
    localparam int PW     = $clog2(DMAX + 1);

    logic [PW-1:0] div, half, phase;
    logic [2:0]    idx;
    logic [7:0]    sreg;
    logic          dir_rx;

    // Pick the bit period from the two rate selects
    always_comb begin
        if (fast) div = dbl ? PW'(DIV_FF) : PW'(DIV_FS);
        else      div = dbl ? PW'(DIV_CF) : PW'(DIV_CS);
        half = div >> 1;
    end

    // Run eight bit periods in the direction chosen at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; dir_rx <= 1'b0; phase <= '0; idx <= '0;
            sreg <= '0; done_tx <= 1'b0; done_rx <= 1'b0;
        end else begin
            done_tx <= 1'b0;
            done_rx <= 1'b0;
            if (!busy) begin
                if (start_tx || start_rx) begin
                    busy   <= 1'b1;
                    dir_rx <= !start_tx;
                    sreg   <= start_tx ? tx_data : 8'h00;
                    phase  <= '0;
                    idx    <= '0;
                end
            end else begin
                if (dir_rx && phase == half) sreg <= {rx_pin, sreg[7:1]};
                if (phase == div - 1'b1) begin
                    phase <= '0;
                    if (!dir_rx) sreg <= {1'b0, sreg[7:1]};
                    if (idx == 3'd7) begin
                        busy    <= 1'b0;
                        done_tx <= !dir_rx;
                        done_rx <= dir_rx;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

    assign sclk    = !busy || (phase >= half);
    assign dout    = sreg[0];
    assign doe     = busy && !dir_rx;
    assign rx_data = sreg;

    // R10
    phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase < div));
endmodule

// File: rtl/sp_async_tx.sv
// Asynchronous frame transmitter. It sends a start bit, eight data bits,
// then an optional ninth bit and a stop bit. Each bit lasts OVS ticks.
// Assumes the caller offers start only while idle.
module sp_async_tx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic       nine,
    input  logic [7:0] data,
    input  logic       bit9,
    output logic       busy,
    output logic       line,
    output logic       done
);
    localparam int CW = $clog2(OVS);

    logic [10:0]   sreg;
    logic [3:0]    idx, last;
    logic [CW-1:0] cnt;

    // Load a frame on start and step one bit every OVS ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; sreg <= '1; idx <= '0; last <= '0; cnt <= '0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    sreg <= {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
                    last <= nine ? 4'd10 : 4'd9;
                    idx  <= '0;
                    cnt  <= '0;
                end
            end else if (tick) begin
                if (cnt == CW'(OVS - 1)) begin
                    cnt  <= '0;
                    sreg <= {1'b1, sreg[10:1]};
                    if (idx == last) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign line = !busy || sreg[0];

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line);
endmodule

// File: rtl/sp_async_rx.sv
// Asynchronous frame receiver with OVS-times oversampling. A start is taken
// only after the line has been seen high. Each bit is a majority vote of the
// three samples around mid-bit. A done pulse follows mid-stop.
// Assumes OVS is at least 4.
module sp_async_rx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       nine,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] data,
    output logic       bit9,
    output logic       ferr
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;

    logic [1:0]    sync, ones, tot;
    logic          line, busy, armed, vote;
    logic [CW-1:0] cnt;
    logic [3:0]    idx, last;
    logic [8:0]    sh;

    assign line = sync[1];
    assign tot  = ones + {1'b0, line};
    assign vote = tot[1];
    assign last = nine ? 4'd10 : 4'd9;

    // Bring the pin into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    // Detect the start, vote each bit and hand over the frame at mid-stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; armed <= 1'b0; cnt <= '0; idx <= '0; ones <= '0;
            sh <= '0; done <= 1'b0; data <= '0; bit9 <= 1'b0; ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                busy  <= 1'b0;
                armed <= 1'b0;
            end else if (tick) begin
                if (!busy) begin
                    if (line) armed <= 1'b1;
                    else if (armed) begin
                        busy <= 1'b1; cnt <= '0; idx <= '0; ones <= '0;
                    end
                end else begin
                    cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
                    if (cnt == CW'(MID - 1) || cnt == CW'(MID)) ones <= tot;
                    if (cnt == CW'(MID + 1)) begin
                        ones <= '0;
                        idx  <= idx + 1'b1;
                        if (idx == 4'd0) begin
                            if (vote) busy <= 1'b0;
                        end else if (idx == last) begin
                            busy  <= 1'b0;
                            armed <= 1'b0;
                            done  <= 1'b1;
                            ferr  <= !vote;
                            data  <= nine ? sh[7:0] : sh[8:1];
                            bit9  <= nine ? sh[8] : vote;
                        end else begin
                            sh <= {vote, sh[8:1]};
                        end
                    end
                end
            end
        end
    end

    // R5
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/mm_serial_port.sv
// Multi-mode serial port top. It routes writes to the shift engine or to the
// asynchronous transmitter, and owns the receive holding register and the
// two sticky flags. Assumes mode and rate selects change only while idle.
module mm_serial_port #(
    parameter int OVS    = 16,
    parameter int DIV_CS = 6,
    parameter int DIV_CF = 3,
    parameter int DIV_FS = 4,
    parameter int DIV_FF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       shift_fast,
    input  logic       shift_x2,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tx_bit9,
    input  logic       rx_go,
    input  logic       clr_tx_flag,
    input  logic       clr_rx_flag,
    input  logic       rxd_in,
    output logic       rxd_out,
    output logic       rxd_oe,
    output logic       txd,
    output logic [7:0] rd_data,
    output logic       rd_bit9,
    output logic       frame_err,
    output logic       tx_flag,
    output logic       rx_flag
);
    import sp_pkg::*;

    logic       is_shift, nine, tx_busy, wr_go;
    logic       a_busy, a_line, a_done;
    logic       s_busy, s_clk, s_tx_done, s_rx_done;
    logic [7:0] s_data, r_data;
    logic       r_done, r_bit9, r_ferr, rx_done;

    assign is_shift = mode_is_shift(mode);
    assign nine     = mode_has_nine(mode);
    assign tx_busy  = a_busy || s_busy;
    assign wr_go    = wr_en && !tx_busy;
    assign rx_done  = r_done || s_rx_done;

    sp_async_tx #(.OVS(OVS)) u_atx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick),
        .start(wr_go && !is_shift), .nine(nine),
        .data(wr_data), .bit9(tx_bit9),
        .busy(a_busy), .line(a_line), .done(a_done)
    );

    sp_async_rx #(.OVS(OVS)) u_arx (
        .clk(clk), .rst_n(rst_n), .en(!is_shift), .tick(baud_tick),
        .nine(nine), .rxd(rxd_in), .done(r_done),
        .data(r_data), .bit9(r_bit9), .ferr(r_ferr)
    );

    sp_shift_engine #(.DIV_CS(DIV_CS), .DIV_CF(DIV_CF), .DIV_FS(DIV_FS), .DIV_FF(DIV_FF)) u_shift (
        .clk(clk), .rst_n(rst_n), .fast(shift_fast), .dbl(shift_x2),
        .start_tx(wr_go && is_shift), .start_rx(rx_go && is_shift),
        .tx_data(wr_data), .rx_pin(rxd_in),
        .busy(s_busy), .sclk(s_clk), .dout(rxd_out), .doe(rxd_oe),
        .done_tx(s_tx_done), .done_rx(s_rx_done), .rx_data(s_data)
    );

    assign txd = is_shift ? s_clk : a_line;

    // Keep the flags and fill the holding register, discarding a frame that finds it full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0; rd_bit9 <= 1'b0; frame_err <= 1'b0;
            tx_flag <= 1'b0; rx_flag <= 1'b0;
        end else begin
            if (clr_tx_flag) tx_flag <= 1'b0;
            if (a_done || s_tx_done) tx_flag <= 1'b1;
            if (clr_rx_flag) begin
                rx_flag   <= 1'b0;
                frame_err <= 1'b0;
            end
            if (rx_done && !rx_flag) begin
                rd_data   <= r_done ? r_data : s_data;
                rd_bit9   <= r_done && r_bit9;
                frame_err <= r_done && r_ferr;
                rx_flag   <= 1'b1;
            end
        end
    end

    // R8
    overrun_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_flag) |=> $stable(rd_data));

    // R5
    rx_flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_flag) |=> rx_flag);

    // R12
    tx_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) |-> $past(a_done || s_tx_done));

    // R4
    no_double_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_busy && s_busy));
endmodule

// File: tb/test_mm_serial_port.sv
`timescale 1ns/1ps
module test_mm_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       shift_fast = 1'b0, shift_x2 = 1'b0, baud_tick = 1'b0;
    logic       wr_en = 1'b0, tx_bit9 = 1'b0, rx_go = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       clr_tx_flag = 1'b0, clr_rx_flag = 1'b0, rxd_in = 1'b1;
    logic       rxd_out, rxd_oe, txd, rd_bit9, frame_err, tx_flag, rx_flag;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct { logic [7:0] d; logic b9; logic fe; int div; } item_t;
    item_t tx_q[$];
    item_t rx_q[$];

    mm_serial_port i_mm_serial_port (
        .clk(clk), .rst_n(rst_n), .mode(mode), .shift_fast(shift_fast),
        .shift_x2(shift_x2), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .tx_bit9(tx_bit9), .rx_go(rx_go),
        .clr_tx_flag(clr_tx_flag), .clr_rx_flag(clr_rx_flag), .rxd_in(rxd_in),
        .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd), .rd_data(rd_data),
        .rd_bit9(rd_bit9), .frame_err(frame_err), .tx_flag(tx_flag), .rx_flag(rx_flag)
    );

    always #10 clk = ~clk;

    // one tick every four clocks: 64 cycles per asynchronous bit
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d, input logic b9);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; tx_bit9 = b9;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr_tx();
        @(negedge clk); clr_tx_flag = 1'b1;
        @(negedge clk); clr_tx_flag = 1'b0;
    endtask

    task automatic pulse_clr_rx();
        @(negedge clk); clr_rx_flag = 1'b1;
        @(negedge clk); clr_rx_flag = 1'b0;
    endtask

    task automatic send_async(input logic [7:0] d, input logic b9, input logic stp, input logic with9);
        @(negedge clk);
        rxd_in = 1'b0;
        repeat (64) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd_in = d[k];
            repeat (64) @(negedge clk);
        end
        if (with9) begin
            rxd_in = b9;
            repeat (64) @(negedge clk);
        end
        rxd_in = stp;
        repeat (64) @(negedge clk);
        rxd_in = 1'b1;
        repeat (64) @(negedge clk);
    endtask

    task automatic shift_in(input logic [7:0] d);
        rxd_in = d[0];
        @(negedge clk); rx_go = 1'b1;
        @(negedge clk); rx_go = 1'b0;
        for (int k = 1; k < 8; k++) begin
            @(posedge txd);
            @(negedge txd);
            @(negedge clk);
            rxd_in = d[k];
        end
        repeat (16) @(negedge clk);
        rxd_in = 1'b1;
    endtask

    task automatic drain_tx();
        while (tx_q.size() != 0) @(negedge clk);
        while (!tx_flag) @(negedge clk);
    endtask

    task automatic drain_rx();
        while (rx_q.size() != 0) @(negedge clk);
    endtask

    // transmit monitor: decodes frames on the pins and compares them with the queue
    initial begin
        wait (rst_n);
        forever begin
            logic [7:0] obs;
            logic       st, nb, sp;
            time        t0, t1;
            int         per;
            item_t      e;
            @(negedge txd);
            #1;
            if (mode == 2'b00) begin
                if (rxd_oe) begin
                    obs = '0; t0 = 0; t1 = 0;
                    for (int k = 0; k < 8; k++) begin
                        @(posedge txd);
                        if (k == 0) t0 = $time;
                        if (k == 1) t1 = $time;
                        @(negedge clk);
                        obs[k] = rxd_out;
                    end
                    per = int'((t1 - t0) / 20);
                    if (tx_q.size() == 0) check(1'b0, "R4 unexpected shift frame", obs, 0);
                    else begin
                        e = tx_q.pop_front();
                        check(obs == e.d, "R10 shift data", obs, e.d);
                        check(per == e.div, "R10 shift period", per, e.div);
                    end
                end
            end else begin
                obs = '0;
                repeat (32) @(negedge clk);
                st = txd;
                for (int k = 0; k < 8; k++) begin
                    repeat (64) @(negedge clk);
                    obs[k] = txd;
                end
                repeat (64) @(negedge clk);
                nb = txd;
                sp = nb;
                if (mode[1]) begin
                    repeat (64) @(negedge clk);
                    sp = txd;
                end
                if (tx_q.size() == 0) check(1'b0, "R4 unexpected async frame", obs, 0);
                else begin
                    e = tx_q.pop_front();
                    check(st == 1'b0, "R2 start bit", st, 0);
                    check(obs == e.d, "R2 async data", obs, e.d);
                    check(nb == e.b9, "R3 ninth or stop bit", nb, e.b9);
                    check(sp == 1'b1, "R3 stop bit", sp, 1);
                end
            end
        end
    end

    // receive monitor: compares the holding register each time it fills
    initial begin
        wait (rst_n);
        forever begin
            item_t e;
            @(posedge rx_flag);
            @(negedge clk);
            if (rx_q.size() == 0) check(1'b0, "R8 unexpected receive", rd_data, 0);
            else begin
                e = rx_q.pop_front();
                check(rd_data == e.d, "R5 received byte", rd_data, e.d);
                check(rd_bit9 == e.b9, "R6 received ninth bit", rd_bit9, e.b9);
                check(frame_err == e.fe, "R7 framing flag", frame_err, e.fe);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle", txd, 1);
        check(rxd_oe == 1'b0, "R1 oe off", rxd_oe, 0);
        check({tx_flag, rx_flag, frame_err, rd_bit9} == 4'b0, "R1 flags", {tx_flag, rx_flag, frame_err, rd_bit9}, 0);
        check(rd_data == 8'h00, "R1 holding", rd_data, 0);

        // R2 and R4: 10-bit frame, with a second write during it
        mode = 2'b01;
        tx_q.push_back('{d: 8'hA5, b9: 1'b1, fe: 1'b0, div: 0});
        write_byte(8'hA5, 1'b0);
        repeat (100) @(negedge clk);
        write_byte(8'h11, 1'b1);
        drain_tx();
        check(tx_flag == 1'b1, "R2 tx done flag", tx_flag, 1);
        repeat (900) @(negedge clk);
        check(txd == 1'b1, "R4 line idle after ignored write", txd, 1);
        check(tx_flag == 1'b1, "R12 tx flag held", tx_flag, 1);
        pulse_clr_tx();
        check(tx_flag == 1'b0, "R12 tx flag cleared", tx_flag, 0);

        // R3: 11-bit frames with both ninth-bit values
        mode = 2'b10;
        tx_q.push_back('{d: 8'h3C, b9: 1'b1, fe: 1'b0, div: 0});
        write_byte(8'h3C, 1'b1);
        drain_tx();
        pulse_clr_tx();
        tx_q.push_back('{d: 8'hC3, b9: 1'b0, fe: 1'b0, div: 0});
        write_byte(8'hC3, 1'b0);
        drain_tx();
        pulse_clr_tx();

        // R5: 10-bit receive, stop bit lands in rd_bit9
        mode = 2'b01;
        repeat (100) @(negedge clk);
        rx_q.push_back('{d: 8'h5A, b9: 1'b1, fe: 1'b0, div: 0});
        send_async(8'h5A, 1'b0, 1'b1, 1'b0);
        drain_rx();
        pulse_clr_rx();

        // R6: 11-bit receive
        mode = 2'b11;
        repeat (100) @(negedge clk);
        rx_q.push_back('{d: 8'h96, b9: 1'b0, fe: 1'b0, div: 0});
        send_async(8'h96, 1'b0, 1'b1, 1'b1);
        drain_rx();
        pulse_clr_rx();
        rx_q.push_back('{d: 8'h69, b9: 1'b1, fe: 1'b0, div: 0});
        send_async(8'h69, 1'b1, 1'b1, 1'b1);
        drain_rx();
        pulse_clr_rx();

        // R7: framing error, byte still delivered
        mode = 2'b01;
        repeat (100) @(negedge clk);
        rx_q.push_back('{d: 8'hE7, b9: 1'b0, fe: 1'b1, div: 0});
        send_async(8'hE7, 1'b0, 1'b0, 1'b0);
        drain_rx();
        check(frame_err == 1'b1, "R7 framing flag set", frame_err, 1);
        pulse_clr_rx();
        check(frame_err == 1'b0, "R7 framing flag cleared", frame_err, 0);

        // R8: overrun keeps the old byte
        rx_q.push_back('{d: 8'h12, b9: 1'b1, fe: 1'b0, div: 0});
        send_async(8'h12, 1'b0, 1'b1, 1'b0);
        drain_rx();
        send_async(8'h34, 1'b0, 1'b1, 1'b0);
        check(rd_data == 8'h12, "R8 old byte kept", rd_data, 8'h12);
        check(rx_flag == 1'b1, "R12 rx flag held", rx_flag, 1);
        pulse_clr_rx();
        check(rx_flag == 1'b0, "R12 rx flag cleared", rx_flag, 0);

        // R13: clear during the next frame, that frame is accepted
        rx_q.push_back('{d: 8'h55, b9: 1'b1, fe: 1'b0, div: 0});
        send_async(8'h55, 1'b0, 1'b1, 1'b0);
        drain_rx();
        rx_q.push_back('{d: 8'hAA, b9: 1'b1, fe: 1'b0, div: 0});
        fork
            begin
                repeat (320) @(negedge clk);
                clr_rx_flag = 1'b1;
                @(negedge clk);
                clr_rx_flag = 1'b0;
            end
        join_none
        send_async(8'hAA, 1'b0, 1'b1, 1'b0);
        drain_rx();
        check(rd_data == 8'hAA, "R13 buffered frame accepted", rd_data, 8'hAA);
        pulse_clr_rx();

        // R9: short low glitch starts nothing
        @(negedge clk);
        rxd_in = 1'b0;
        repeat (12) @(negedge clk);
        rxd_in = 1'b1;
        repeat (1000) @(negedge clk);
        check(rx_flag == 1'b0, "R9 glitch rejected", rx_flag, 0);

        // R10: shift transmit at every rate
        mode = 2'b00;
        for (int r = 0; r < 4; r++) begin
            shift_fast = r[1];
            shift_x2   = r[0];
            tx_q.push_back('{d: 8'h4D + 8'(r), b9: 1'b0, fe: 1'b0,
                             div: (r == 0) ? 6 : (r == 1) ? 3 : (r == 2) ? 4 : 2});
            write_byte(8'h4D + 8'(r), 1'b0);
            drain_tx();
            check(rxd_oe == 1'b0, "R10 oe released", rxd_oe, 0);
            pulse_clr_tx();
        end

        // R11: shift receive at the slowest and fastest rates
        shift_fast = 1'b0; shift_x2 = 1'b0;
        rx_q.push_back('{d: 8'hC5, b9: 1'b0, fe: 1'b0, div: 0});
        shift_in(8'hC5);
        drain_rx();
        pulse_clr_rx();
        shift_fast = 1'b1; shift_x2 = 1'b1;
        rx_q.push_back('{d: 8'h3A, b9: 1'b0, fe: 1'b0, div: 0});
        shift_in(8'h3A);
        drain_rx();
        check(rd_data == 8'h3A, "R11 shift byte held", rd_data, 8'h3A);
        pulse_clr_rx();

        repeat (50) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule